// File: doc/BRIEF.md
# UART FIFO Register Window

This block sits between an 8-bit processor bus and the two byte queues of a serial port. It holds a transmit queue and a receive queue, each sixteen bytes deep, and shows them to software through a two-byte address window. The word at the even address is the data port. A bus write there enqueues a byte for the transmitter. A bus read there returns the oldest received byte and removes it from the queue. The word at the odd address is a read-only status byte that reports whether the transmit queue is full and whether the receive queue is empty.

On the serial side, the receiver engine offers bytes through a push port and sees a full flag. The transmitter engine takes bytes through a pop port and sees an empty flag. A level interrupt tells the processor that received bytes are waiting. It stays high until software has read every byte out.

Bus reads are combinational within the selected cycle. Each clock cycle in which the data address is selected without the write strobe counts as one read and removes exactly one byte.

Top module: `uart_regif`

## Requirements
- R1: A bus cycle with `busSel`=1, `busWr`=1 and `busAddr`=0 enqueues `busWdata` into the transmit queue. Enqueued bytes leave on `txPopData` in the order they were written, one per cycle with `txPopReq`=1.
- R2: A bus cycle with `busSel`=1, `busWr`=0 and `busAddr`=0 shows the oldest receive byte on `busRdata` in that same cycle, and removes that byte at the closing clock edge.
- R3: Status bit 0 (read with `busAddr`=1) is 1 exactly when the transmit queue holds 16 bytes.
- R4: Status bit 1 is 1 exactly when the receive queue is empty. Status bits 7:2 always read 0.
- R5: `irqOut` is high while the receive queue holds at least one byte, and low once it is drained.
- R6: A bus write to the data address while the transmit queue is full is dropped. The queued contents and their order are unchanged.
- R7: A bus read of the data address while the receive queue is empty returns 0x00 and changes no state.
- R8: When a queue is neither empty nor full, a push and a pop in the same cycle both take effect. Its occupancy then stays the same and its order is kept.
- R9: A bus write to the status address has no effect on either queue.
- R10: A receiver push while the receive queue is full (`rxFull`=1) is dropped.
- R11: A bus read of the status address removes no byte from the receive queue.
- R12: After reset both queues are empty, `irqOut`=0, `txEmpty`=1, `rxFull`=0 and status reads 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus select for the two-byte window |
| busAddr | input | 1 | 0 = data port, 1 = status byte |
| busWr | input | 1 | 1 = write cycle, 0 = read cycle |
| busWdata | input | 8 | Bus write data |
| busRdata | output | 8 | Bus read data, valid during the selected read cycle |
| irqOut | output | 1 | Level interrupt, high while received bytes wait |
| rxPushValid | input | 1 | Receiver offers a byte |
| rxPushData | input | 8 | Byte from the receiver |
| rxFull | output | 1 | Receive queue full |
| txPopReq | input | 1 | Transmitter takes the head byte |
| txPopData | output | 8 | Head byte of the transmit queue (0 when empty) |
| txEmpty | output | 1 | Transmit queue empty |

## Verification
The hardest cases to reach are the ones where both sides of a queue move in the same cycle. In one, the receiver pushes while the processor reads the data port. In the other, the processor writes while the transmitter pops. A sequential bench tends to keep these events apart. The stimulus first partly fills each queue. It then drives the bus and the serial-side port together in one cycle, and drains the queue afterwards against the scoreboard, so that any lost or duplicated byte shows up as a mismatch. The full-queue drops are reached by writing or pushing sixteen bytes followed by one extra byte. The dropped byte must not appear in the drained sequence.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam logic ADDR_DATA   = 1'b0;
  localparam logic ADDR_STATUS = 1'b1;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic rdData;
    logic rdStatus;
  } busStrb_t;
endpackage

// File: rtl/uart_regif_fifo.sv
module uart_regif_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic [WIDTH-1:0] headData,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr, count;
  logic pushOk, popOk;

  assign count  = wrPtr - rdPtr;
  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  assign pushOk = pushEn && !full;
  assign popOk  = popEn && !empty;
  assign headData = empty ? '0 : mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (pushOk) begin
        mem[wrPtr[AW-1:0]] <= pushData;
        wrPtr <= wrPtr + 1'b1;
      end
      if (popOk) rdPtr <= rdPtr + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    full && pushEn && !popEn |=> full && count == $past(count)); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    empty && popEn && !pushEn |=> empty); // R7
  AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    pushEn && popEn && !full && !empty |=> count == $past(count)); // R8
endmodule

// File: rtl/uart_regif_ctrl.sv
module uart_regif_ctrl
  import uart_regif_pkg::*;
(
  input  logic     busSel,
  input  logic     busAddr,
  input  logic     busWr,
  output busStrb_t strb
);
  always_comb begin
    strb = '0;
    if (busSel) begin
      if (busWr) begin
        strb.txPush = (busAddr == ADDR_DATA);
      end else begin
        strb.rxPop    = (busAddr == ADDR_DATA);
        strb.rdData   = (busAddr == ADDR_DATA);
        strb.rdStatus = (busAddr == ADDR_STATUS);
      end
    end
  end
endmodule

// File: rtl/uart_regif_dp.sv
module uart_regif_dp
  import uart_regif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrb_t          strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  input  logic              rxPushValid,
  input  logic [DATA_W-1:0] rxPushData,
  output logic              rxFull,
  input  logic              txPopReq,
  output logic [DATA_W-1:0] txPopData,
  output logic              txEmpty
);
  localparam int PAD_W = DATA_W - 2;

  logic txFull, rxEmpty;
  logic [DATA_W-1:0] rxHead;

  uart_regif_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) txFifo_i (
    .clk(clk), .rstN(rstN),
    .pushEn(strb.txPush), .pushData(busWdata),
    .popEn(txPopReq), .headData(txPopData),
    .full(txFull), .empty(txEmpty)
  );

  uart_regif_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) rxFifo_i (
    .clk(clk), .rstN(rstN),
    .pushEn(rxPushValid), .pushData(rxPushData),
    .popEn(strb.rxPop), .headData(rxHead),
    .full(rxFull), .empty(rxEmpty)
  );

  always_comb begin
    if (strb.rdData)        busRdata = rxHead;
    else if (strb.rdStatus) busRdata = {{PAD_W{1'b0}}, rxEmpty, txFull};
    else                    busRdata = '0;
  end

  assign irqOut = !rxEmpty;

  AST_IRQ_ON_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rxPushValid && !rxFull |=> irqOut); // R5
  AST_STATUS_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdStatus && irqOut |=> irqOut); // R11
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  input  logic              rxPushValid,
  input  logic [DATA_W-1:0] rxPushData,
  output logic              rxFull,
  input  logic              txPopReq,
  output logic [DATA_W-1:0] txPopData,
  output logic              txEmpty
);
  busStrb_t strb;

  uart_regif_ctrl ctrl_i (
    .busSel(busSel), .busAddr(busAddr), .busWr(busWr), .strb(strb)
  );

  uart_regif_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .rxPushValid(rxPushValid), .rxPushData(rxPushData), .rxFull(rxFull),
    .txPopReq(txPopReq), .txPopData(txPopData), .txEmpty(txEmpty)
  );
endmodule

// File: tb/uart_regif_tb_top.sv
module uart_regif_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busAddr = 1'b0, busWr = 1'b0;
  logic [7:0] busWdata = '0, rxPushData = '0;
  logic rxPushValid = 1'b0, txPopReq = 1'b0;
  logic [7:0] busRdata, txPopData;
  logic irqOut, rxFull, txEmpty;

  int checks = 0;
  int errors = 0;
  byte unsigned txQ[$];
  byte unsigned rxQ[$];

  always #4 clk = ~clk;

  uart_regif dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .rxPushValid(rxPushValid), .rxPushData(rxPushData), .rxFull(rxFull),
    .txPopReq(txPopReq), .txPopData(txPopData), .txEmpty(txEmpty)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  // driver: bus write, updates scoreboard with what must be enqueued
  task automatic cpuWrite(input logic a, input byte unsigned d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWr = 0;
    if (a == 1'b0 && txQ.size() < 16) txQ.push_back(d);
  endtask

  // driver: receiver push
  task automatic rxInject(input byte unsigned d);
    @(negedge clk);
    rxPushValid = 1; rxPushData = d;
    @(posedge clk); #1;
    rxPushValid = 0;
    if (rxQ.size() < 16) rxQ.push_back(d);
  endtask

  // monitor: bus read of data port compared with scoreboard head
  task automatic cpuReadData(input string req);
    int exp;
    exp = (rxQ.size() == 0) ? 0 : rxQ[0];
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = 1'b0;
    #1 chk(req, busRdata, exp);
    @(posedge clk); #1;
    busSel = 0;
    if (rxQ.size() != 0) void'(rxQ.pop_front());
  endtask

  task automatic cpuReadStatus(input string req, input int exp);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = 1'b1;
    #1 chk(req, busRdata, exp);
    @(posedge clk); #1;
    busSel = 0;
  endtask

  // monitor: transmitter side drains and compares
  task automatic txDrain(input string req);
    int exp;
    exp = (txQ.size() == 0) ? 0 : txQ[0];
    @(negedge clk);
    txPopReq = 1;
    #1 chk(req, txPopData, exp);
    @(posedge clk); #1;
    txPopReq = 0;
    if (txQ.size() != 0) void'(txQ.pop_front());
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog got 0 exp 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R12 reset state
    #1;
    chk("R12 irq", irqOut, 0);
    chk("R12 txEmpty", txEmpty, 1);
    chk("R12 rxFull", rxFull, 0);
    cpuReadStatus("R12 status", 8'h02);

    // R1 write order
    cpuWrite(0, 8'h41); cpuWrite(0, 8'h42); cpuWrite(0, 8'h43);
    chk("R1 txEmpty", txEmpty, 0);
    while (txQ.size() != 0) txDrain("R1 order");
    chk("R1 drained", txEmpty, 1);

    // R2 R5 receive path
    rxInject(8'h3F); rxInject(8'h10); rxInject(8'hA5);
    chk("R5 irq high", irqOut, 1);
    cpuReadStatus("R4 status", 8'h00);
    cpuReadStatus("R11 status again", 8'h00);
    while (rxQ.size() != 0) cpuReadData("R2 order");
    chk("R5 irq low", irqOut, 0);
    cpuReadStatus("R4 empty", 8'h02);

    // R7 empty read
    cpuReadData("R7 empty read");
    cpuReadStatus("R7 state", 8'h02);
    chk("R7 irq", irqOut, 0);

    // R3 R6 transmit full and drop
    for (int i = 0; i < 16; i++) cpuWrite(0, 8'(8'h60 + i));
    cpuReadStatus("R3 full", 8'h03);
    cpuWrite(0, 8'hEE);
    cpuReadStatus("R6 still full", 8'h03);
    while (txQ.size() != 0) txDrain("R6 order");
    chk("R6 empty", txEmpty, 1);
    txDrain("R6 empty pop zero");

    // R9 status write ignored
    cpuWrite(1, 8'h77);
    chk("R9 txEmpty", txEmpty, 1);
    cpuReadStatus("R9 status", 8'h02);

    // R10 receive full drop, R11 status read no pop
    for (int i = 0; i < 16; i++) rxInject(8'(8'h80 + i));
    chk("R10 rxFull", rxFull, 1);
    rxInject(8'hCC);
    cpuReadStatus("R11 status", 8'h00);
    cpuReadData("R11 head");
    chk("R10 not full", rxFull, 0);
    while (rxQ.size() != 0) cpuReadData("R10 order");

    // R8 simultaneous on receive queue
    rxInject(8'h01); rxInject(8'h02);
    @(negedge clk);
    rxPushValid = 1; rxPushData = 8'h03;
    busSel = 1; busWr = 0; busAddr = 0;
    #1 chk("R8 rx head", busRdata, rxQ[0]);
    @(posedge clk); #1;
    rxPushValid = 0; busSel = 0;
    void'(rxQ.pop_front()); rxQ.push_back(8'h03);
    while (rxQ.size() != 0) cpuReadData("R8 rx order");
    chk("R8 rx drained", irqOut, 0);

    // R8 simultaneous on transmit queue
    cpuWrite(0, 8'h11); cpuWrite(0, 8'h12);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = 0; busWdata = 8'h13;
    txPopReq = 1;
    #1 chk("R8 tx head", txPopData, txQ[0]);
    @(posedge clk); #1;
    busSel = 0; busWr = 0; txPopReq = 0;
    void'(txQ.pop_front()); txQ.push_back(8'h13);
    while (txQ.size() != 0) txDrain("R8 tx order");
    chk("R8 tx drained", txEmpty, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule